// File: doc/BRIEF.md
# Preemptible Burst SRAM Arbiter

This block owns one external 256K x 8 asynchronous SRAM and shares it among three clients. Two video frame-buffer streams move data in 32-byte bursts. One stream writes and the other reads, and each has its own internal byte FIFO. A CPU port needs a reply within about a microsecond and cannot wait for a burst to finish.

The controller moves one byte per clock. At 18.432 MHz an uninterrupted burst takes about 1.74 us. A CPU strobe always takes the very next byte slot. The running burst simply stalls for that slot and then continues from the same address and byte count, so no video byte is lost or repeated.

The upper 64 KB of the SRAM belongs to the CPU, and CPU addresses are offsets into it. Video bursts are chosen round-robin whenever the engine is idle.

Video data and burst commands use valid/ready handshakes:
- A transfer happens on a clock edge where valid and ready are both high.
- A source must hold its valid signal and its payload until that transfer.
- Command ready may depend on command valid in the same cycle.
- The read-data output holds its byte for as long as ready is low.

The CPU strobe and its ready pulse are plain control pins.

Top module: `fbuf_sram_arb`

## Requirements
- R1: While reset is held and right after it is released, the SRAM is deselected (chip enable and write enable both high, i.e. inactive), cpu_ready is 0, rd_dat_valid is 0, both command readys are 0, and wr_dat_ready is 1.
- R2: A CPU access uses SRAM address 0x30000 plus cpu_addr[15:0]. Bits 17:16 of cpu_addr are ignored. A read returns the stored byte on cpu_rdata in the cycle that cpu_ready is high.
- R3: A cpu_req sampled high at clock edge k is performed on the SRAM in the cycle after edge k. cpu_ready is then high for the cycle after edge k+1. This holds whether or not a burst is running.
- R4: A write burst command is accepted only when the write FIFO holds at least 32 bytes. The burst then writes the next 32 FIFO bytes, in order, to 32 ascending addresses starting at wr_cmd_addr.
- R5: A read burst command is accepted only when the read FIFO has at least 32 free entries. The burst reads 32 ascending addresses from rd_cmd_addr and delivers the bytes in address order on rd_dat.
- R6: A CPU access during a burst stalls that burst for exactly one byte slot. The burst then resumes with the same next address and remaining count, so memory ends up with every burst byte exactly once.
- R7: When both video commands are eligible while the engine is idle, the stream not served last is granted. After reset, the write stream is the one counted as not served last.
- R8: wr_dat_ready is low whenever the write FIFO holds 64 bytes. rd_dat_valid is low when the read FIFO is empty. rd_dat stays unchanged while rd_dat_valid is high and rd_dat_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd_valid | input | 1 | Write burst command valid |
| wr_cmd_ready | output | 1 | Write burst command accepted this edge |
| wr_cmd_addr | input | 18 | Write burst start address |
| wr_dat_valid | input | 1 | Write stream byte valid |
| wr_dat_ready | output | 1 | Write FIFO can take a byte |
| wr_dat | input | 8 | Write stream byte |
| rd_cmd_valid | input | 1 | Read burst command valid |
| rd_cmd_ready | output | 1 | Read burst command accepted this edge |
| rd_cmd_addr | input | 18 | Read burst start address |
| rd_dat_valid | output | 1 | Read FIFO has a byte |
| rd_dat_ready | input | 1 | Consumer takes the byte |
| rd_dat | output | 8 | Read stream byte |
| cpu_req | input | 1 | One-cycle CPU access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 18 | CPU offset; only bits 15:0 used |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| sram_addr | output | 18 | SRAM address |
| sram_dq_o | output | 8 | Data driven to SRAM |
| sram_dq_i | input | 8 | Data returned by SRAM |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |

## Verification
The CPU result has a fixed due time. The bench drives cpu_req at a falling edge and reads cpu_ready and cpu_rdata at the second falling edge after that, which is just past edge k+1. Command readys are combinational, so the bench samples them 1 ns after raising valid.

A burst runs for 32 byte slots plus one slot per CPU access that interrupts it. The bench waits a margin of at least 40 cycles before comparing its SRAM model or popping the read FIFO. Read bytes are sampled at falling edges while rd_dat_ready is high.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  typedef enum logic {SID_WR = 1'b0, SID_RD = 1'b1} sid_e;
  typedef enum logic {ENG_IDLE = 1'b0, ENG_RUN = 1'b1} eng_e;
endpackage

// File: rtl/sram_byte_fifo.sv
module sram_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign dout  = store[rp];
  assign count = cnt;

  // The producer must never push into a full FIFO.
  assert_fifo_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH)));
  // The consumer must never pop an empty FIFO.
  assert_fifo_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/stream_rr_arb.sv
module stream_rr_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         take,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last;
  logic [IW-1:0] win;
  logic          found;

  always_comb begin
    gnt   = '0;
    win   = last;
    found = 1'b0;
    for (int off = 1; off <= N; off++) begin
      logic [IW-1:0] cand;
      cand = IW'((int'(last) + off) % N);
      if (!found && req[cand]) begin
        gnt[cand] = 1'b1;
        win       = cand;
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                last <= IW'(N-1);
    else if (take && found)    last <= win;
  end

  // When every stream competes, the grant must move away from the last winner.
  assert_rr_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (&req)) |=> (last != $past(last)));
endmodule

// File: rtl/cpu_slot.sv
module cpu_slot #(
  parameter int AW       = 18,
  parameter int DW       = 8,
  parameter int CPU_AW   = 16,
  parameter int FB_BYTES = 196608
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [CPU_AW-1:0] offs,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     sram_din,
  output logic              pend,
  output logic              pend_we,
  output logic [AW-1:0]     pend_addr,
  output logic [DW-1:0]     pend_wdata,
  output logic              ready,
  output logic [DW-1:0]     rdata
);
  localparam logic [AW-1:0] CPU_BASE = AW'(FB_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_we    <= 1'b0;
      pend_addr  <= '0;
      pend_wdata <= '0;
      ready      <= 1'b0;
      rdata      <= '0;
    end else begin
      pend  <= req;
      ready <= pend;
      if (req) begin
        pend_we    <= we;
        pend_addr  <= CPU_BASE + AW'(offs);
        pend_wdata <= wdata;
      end
      if (pend && !pend_we) rdata <= sram_din;
    end
  end

  // Fixed two-edge turnaround from strobe to completion.
  assert_cpu_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req, 2) |-> ready);
endmodule

// File: rtl/fbuf_sram_arb.sv
module fbuf_sram_arb #(
  parameter int AW       = 18,
  parameter int DW       = 8,
  parameter int BURST    = 32,
  parameter int FIFO_DEP = 2 * BURST,
  parameter int FB_BYTES = 196608,
  parameter int CPU_AW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd_valid,
  output logic          wr_cmd_ready,
  input  logic [AW-1:0] wr_cmd_addr,
  input  logic          wr_dat_valid,
  output logic          wr_dat_ready,
  input  logic [DW-1:0] wr_dat,
  input  logic          rd_cmd_valid,
  output logic          rd_cmd_ready,
  input  logic [AW-1:0] rd_cmd_addr,
  output logic          rd_dat_valid,
  input  logic          rd_dat_ready,
  output logic [DW-1:0] rd_dat,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_dq_oe,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n
);
  import fbuf_pkg::*;

  localparam int CW = $clog2(FIFO_DEP + 1);
  localparam int RW = $clog2(BURST + 1);

  // fifos
  logic [CW-1:0] wcnt, rcnt;
  logic [DW-1:0] wf_dout;
  logic          wf_push, wf_pop, rf_push, rf_pop;

  assign wr_dat_ready = (wcnt < CW'(FIFO_DEP));
  assign wf_push      = wr_dat_valid && wr_dat_ready;
  assign rd_dat_valid = (rcnt != '0);
  assign rf_pop       = rd_dat_valid && rd_dat_ready;

  sram_byte_fifo #(.W(DW), .DEPTH(FIFO_DEP)) wfifo_i (
    .clk(clk), .rst_n(rst_n), .push(wf_push), .din(wr_dat),
    .pop(wf_pop), .dout(wf_dout), .count(wcnt));

  sram_byte_fifo #(.W(DW), .DEPTH(FIFO_DEP)) rfifo_i (
    .clk(clk), .rst_n(rst_n), .push(rf_push), .din(sram_dq_i),
    .pop(rf_pop), .dout(rd_dat), .count(rcnt));

  // cpu path
  logic          cpu_pend, cpu_pend_we;
  logic [AW-1:0] cpu_pend_addr;
  logic [DW-1:0] cpu_pend_wdata;
  logic          unused_cpu_hi;
  assign unused_cpu_hi = ^cpu_addr[AW-1:CPU_AW];

  cpu_slot #(.AW(AW), .DW(DW), .CPU_AW(CPU_AW), .FB_BYTES(FB_BYTES)) cpu_i (
    .clk(clk), .rst_n(rst_n), .req(cpu_req), .we(cpu_we),
    .offs(cpu_addr[CPU_AW-1:0]), .wdata(cpu_wdata), .sram_din(sram_dq_i),
    .pend(cpu_pend), .pend_we(cpu_pend_we), .pend_addr(cpu_pend_addr),
    .pend_wdata(cpu_pend_wdata), .ready(cpu_ready), .rdata(cpu_rdata));

  // burst engine
  eng_e          eng;
  sid_e          act_sid;
  logic [AW-1:0] b_addr;
  logic [RW-1:0] b_left;
  logic          step;
  logic [1:0]    vreq, vgnt;
  logic          take;

  assign vreq[0] = wr_cmd_valid && (wcnt >= CW'(BURST));
  assign vreq[1] = rd_cmd_valid && ((CW'(FIFO_DEP) - rcnt) >= CW'(BURST));
  assign take    = (eng == ENG_IDLE) && (|vreq);

  stream_rr_arb #(.N(2)) rr_i (
    .clk(clk), .rst_n(rst_n), .req(vreq), .take(take), .gnt(vgnt));

  assign wr_cmd_ready = take && vgnt[0];
  assign rd_cmd_ready = take && vgnt[1];

  assign step    = (eng == ENG_RUN) && !cpu_pend;
  assign wf_pop  = step && (act_sid == SID_WR);
  assign rf_push = step && (act_sid == SID_RD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng     <= ENG_IDLE;
      act_sid <= SID_WR;
      b_addr  <= '0;
      b_left  <= '0;
    end else if (eng == ENG_IDLE) begin
      if (take) begin
        eng     <= ENG_RUN;
        act_sid <= vgnt[1] ? SID_RD : SID_WR;
        b_addr  <= vgnt[1] ? rd_cmd_addr : wr_cmd_addr;
        b_left  <= RW'(BURST);
      end
    end else if (step) begin
      b_addr <= b_addr + 1'b1;
      b_left <= b_left - 1'b1;
      if (b_left == RW'(1)) eng <= ENG_IDLE;
    end
  end

  // sram pins: cpu slot first, then the running burst
  always_comb begin
    sram_addr  = '0;
    sram_dq_o  = '0;
    sram_dq_oe = 1'b0;
    sram_ce_n  = 1'b1;
    sram_oe_n  = 1'b1;
    sram_we_n  = 1'b1;
    if (cpu_pend) begin
      sram_addr  = cpu_pend_addr;
      sram_dq_o  = cpu_pend_wdata;
      sram_dq_oe = cpu_pend_we;
      sram_ce_n  = 1'b0;
      sram_oe_n  = cpu_pend_we;
      sram_we_n  = !cpu_pend_we;
    end else if (eng == ENG_RUN) begin
      sram_addr  = b_addr;
      sram_dq_o  = wf_dout;
      sram_dq_oe = (act_sid == SID_WR);
      sram_ce_n  = 1'b0;
      sram_oe_n  = (act_sid == SID_WR);
      sram_we_n  = (act_sid != SID_WR);
    end
  end

  // A preempted burst keeps its place exactly.
  assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((eng == ENG_RUN) && cpu_pend) |=> ((eng == ENG_RUN) && $stable(b_addr) && $stable(b_left)));
  // The strobed CPU offset appears on the SRAM address in the next cycle.
  assert_cpu_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_req) |-> (!sram_ce_n && (sram_addr[CPU_AW-1:0] == $past(cpu_addr[CPU_AW-1:0]))));
  // A burst is only granted while no other burst is running.
  assert_single_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng == ENG_RUN) |-> !(wr_cmd_ready || rd_cmd_ready));
endmodule

// File: tb/fbuf_sram_arb_tb_top.sv
module fbuf_sram_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_cmd_valid = 0, wr_dat_valid = 0, rd_cmd_valid = 0, rd_dat_ready = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [17:0] wr_cmd_addr = '0, rd_cmd_addr = '0, cpu_addr = '0;
  logic [7:0]  wr_dat = '0, cpu_wdata = '0;
  logic        wr_cmd_ready, wr_dat_ready, rd_cmd_ready, rd_dat_valid, cpu_ready;
  logic [7:0]  rd_dat, cpu_rdata, sram_dq_o, sram_dq_i;
  logic [17:0] sram_addr;
  logic        sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] mem [int];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mrd(input logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  assign sram_dq_i = (!sram_ce_n && !sram_oe_n) ? mrd(sram_addr) : 8'h00;
  always @(posedge clk) if (!sram_ce_n && !sram_we_n) mem[int'(sram_addr)] = sram_dq_o;

  fbuf_sram_arb dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // we, addr, wdata, expected read byte
  localparam logic [34:0] CPU_VEC [7] = '{
    {1'b1, 18'h00005, 8'hA5, 8'h00},
    {1'b1, 18'h0FFFF, 8'h3C, 8'h00},
    {1'b0, 18'h00005, 8'h00, 8'hA5},
    {1'b0, 18'h10005, 8'h00, 8'hA5},
    {1'b1, 18'h21234, 8'h77, 8'h00},
    {1'b0, 18'h01234, 8'h00, 8'h77},
    {1'b0, 18'h0FFFF, 8'h00, 8'h3C}
  };

  task automatic cpu_op(input logic we, input logic [17:0] a, input logic [7:0] d, output logic [7:0] rd, output logic rdy);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0;
    @(negedge clk);
    rdy = cpu_ready; rd = cpu_rdata;
  endtask

  task automatic push_bytes(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      wr_dat_valid = 1; wr_dat = 8'(i * 7 + seed);
      #1;
      while (!wr_dat_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    wr_dat_valid = 0;
  endtask

  task automatic wr_cmd(input logic [17:0] a);
    wr_cmd_addr = a; wr_cmd_valid = 1;
    #1;
    while (!wr_cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    wr_cmd_valid = 0;
  endtask

  task automatic mem_burst_chk(input int base, input int seed, input string req);
    int errs = 0; int first = -1;
    for (int i = 0; i < 32; i++)
      if (mrd(18'(base + i)) !== 8'(i * 7 + seed)) begin errs++; if (first < 0) first = i; end
    chk(errs == 0, req, "burst bytes in SRAM", first < 0 ? 0 : int'(mrd(18'(base + first))),
        first < 0 ? 0 : int'(8'(first * 7 + seed)));
  endtask

  logic [7:0] r; logic k; bit timeout = 0;

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        chk(sram_ce_n && sram_we_n, "R1", "sram idle in reset", {sram_ce_n, sram_we_n}, 3);
        rst_n = 1;
        @(negedge clk);
        chk(sram_ce_n === 1'b1 && sram_we_n === 1'b1, "R1", "sram deselected", {sram_ce_n, sram_we_n}, 3);
        chk(cpu_ready === 1'b0, "R1", "cpu_ready", cpu_ready, 0);
        chk(rd_dat_valid === 1'b0, "R1", "rd_dat_valid", rd_dat_valid, 0);
        chk(!wr_cmd_ready && !rd_cmd_ready, "R1", "cmd readys", {wr_cmd_ready, rd_cmd_ready}, 0);
        chk(wr_dat_ready === 1'b1, "R1", "wr_dat_ready", wr_dat_ready, 1);

        // table walk: CPU region mapping, masking, latency
        foreach (CPU_VEC[i]) begin
          cpu_op(CPU_VEC[i][34], CPU_VEC[i][33:16], CPU_VEC[i][15:8], r, k);
          chk(k === 1'b1, "R3", "cpu_ready due", k, 1);
          if (!CPU_VEC[i][34]) chk(r === CPU_VEC[i][7:0], "R2", "cpu read data", r, CPU_VEC[i][7:0]);
          @(negedge clk);
          chk(cpu_ready === 1'b0, "R3", "cpu_ready one cycle", cpu_ready, 0);
        end
        chk(mrd(18'h30005) === 8'hA5, "R2", "cpu byte lands at 0x30005", mrd(18'h30005), 8'hA5);
        chk(mrd(18'h31234) === 8'h77, "R2", "high bits ignored", mrd(18'h31234), 8'h77);

        // write burst, not eligible before 32 bytes
        push_bytes(31, 3);
        wr_cmd_addr = 18'h00100; wr_cmd_valid = 1; #1;
        chk(wr_cmd_ready === 1'b0, "R4", "no grant under 32 bytes", wr_cmd_ready, 0);
        wr_cmd_valid = 0;
        @(negedge clk);
        wr_dat_valid = 1; wr_dat = 8'(31 * 7 + 3); @(negedge clk); wr_dat_valid = 0;
        wr_cmd(18'h00100);
        repeat (40) @(negedge clk);
        mem_burst_chk(32'h100, 3, "R4");

        // read burst back
        rd_cmd_addr = 18'h00100; rd_cmd_valid = 1; #1;
        while (!rd_cmd_ready) begin @(negedge clk); #1; end
        @(negedge clk); rd_cmd_valid = 0;
        repeat (40) @(negedge clk);
        r = rd_dat;
        repeat (3) @(negedge clk);
        chk(rd_dat_valid && rd_dat === r, "R8", "rd_dat held while stalled", rd_dat, r);
        begin
          int errs = 0;
          rd_dat_ready = 1;
          for (int i = 0; i < 32; i++) begin
            if (!rd_dat_valid || rd_dat !== 8'(i * 7 + 3)) errs++;
            @(negedge clk);
          end
          rd_dat_ready = 0;
          chk(errs == 0, "R5", "read burst order", errs, 0);
        end
        chk(rd_dat_valid === 1'b0, "R8", "valid low when empty", rd_dat_valid, 0);

        // preempted write burst
        push_bytes(32, 11);
        wr_cmd(18'h00200);
        repeat (4) @(negedge clk);
        cpu_op(1'b1, 18'h00200, 8'h5A, r, k);
        chk(k === 1'b1, "R3", "ready during burst", k, 1);
        cpu_op(1'b0, 18'h00200, 8'h00, r, k);
        chk(k === 1'b1 && r === 8'h5A, "R3", "read during burst", r, 8'h5A);
        repeat (40) @(negedge clk);
        mem_burst_chk(32'h200, 11, "R6");

        // full FIFO back-pressure
        push_bytes(64, 20);
        wr_dat_valid = 1; #1;
        chk(wr_dat_ready === 1'b0, "R8", "wr_dat_ready low at 64", wr_dat_ready, 0);
        wr_dat_valid = 0;

        // round-robin: last served was the write stream
        begin
          int rd_at = -1, wr_at = -1;
          rd_cmd_addr = 18'h00300; wr_cmd_addr = 18'h00400;
          @(negedge clk);
          fork
            begin
              rd_cmd_valid = 1; #1;
              while (!rd_cmd_ready) begin @(negedge clk); #1; end
              rd_at = cyc; @(negedge clk); rd_cmd_valid = 0;
            end
            begin
              wr_cmd_valid = 1; #1;
              while (!wr_cmd_ready) begin @(negedge clk); #1; end
              wr_at = cyc; @(negedge clk); wr_cmd_valid = 0;
            end
          join
          chk(rd_at < wr_at, "R7", "read granted before write", rd_at, wr_at);
        end
        repeat (40) @(negedge clk);
        mem_burst_chk(32'h400, 20, "R4");
      end
      begin
        repeat (100000) @(posedge clk);
        timeout = 1;
      end
    join_any
    if (timeout) chk(1'b0, "R1", "watchdog expired", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule